// File: doc/BRIEF.md
# Per-Core Interrupt Timer

This block is the countdown and deadline timer that sits beside each core's local interrupt logic. Software programs it through a small word-addressed register port. One register selects the interrupt vector and the operating mode. A second sets the prescaler. A third holds the reload value. A fourth can be read to see the running count. Two more words hold a 64-bit absolute deadline, which is compared with a free-running timestamp supplied from outside.

The block has three modes. In one-shot mode the count runs down to zero once and stops there. In periodic mode the count reloads each time it expires. In deadline mode the block fires when the timestamp reaches the programmed deadline. When the timer fires, it raises one interrupt request that carries the programmed vector. The request stays up until the core returns an acknowledge pulse.

Changing the mode does not disturb the running count. A deadline that has already passed fires at once and then clears itself.

Top module: `core_irq_timer`

## Requirements
- R1: After a synchronous reset, the request is low and the vector output is zero. The control word, reload value, current count and deadline all read as zero.
- R2: The divide register uses bits 3, 1 and 0 to form a code n = {bit3, bit1, bit0}. Code 7 (for example, the value 0xB) advances the count on every clock. Any other code advances it once every 2^(n+1) clocks; for example, the value 0x1 divides by 4.
- R3: Writing the reload value (address 2) loads the current count (read at address 3) and restarts the prescaler. With divide ratio D and value N, the request rises N*D clocks after the write edge.
- R4: In one-shot mode (mode field 0), the count stops at zero after firing, and no further request follows.
- R5: In periodic mode (mode field 1), when the count steps from 1 it reloads from the reload value. This gives a request every N*D clocks.
- R6: Writing the control word (address 0) changes neither the reload value nor the current count. The count keeps running from its present value.
- R7: A current count of zero stays at zero when the mode changes to periodic. No reload and no request follow.
- R8: In deadline mode (mode field 2), a deadline is committed by writing the low word (address 4) and then the high word (address 5). If the committed deadline is at or below the timestamp, the request rises at the next edge, and both deadline words then read as zero.
- R9: A future deadline fires on the first edge at which the timestamp input is at or above it. A deadline of zero is disarmed and never fires.
- R10: The request vector is bits 7:0 of the control word. The mode is bits 18:17 of the control word, and code 3 behaves as one-shot.
- R11: The request stays asserted, with a stable vector, until an acknowledge pulse arrives. While a request is outstanding, further expiries are dropped. If an expiry falls on the same edge as an acknowledge, the request stays asserted for the new expiry. Writing a reload value of zero stops the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Registered read data for the word at rd_addr |
| ts_in | input | 64 | Free-running timestamp |
| irq_ack | input | 1 | Acknowledge pulse for the outstanding request |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector carried by the request |

## Verification
The acknowledge of an outstanding request and a fresh periodic expiry can land on the same clock edge. The bench provokes this with a short periodic reload, left unacknowledged past one expiry. It then times the acknowledge pulse onto the edge of a later expiry, counting edges from the first request. It judges the outcome twice. The request must still be high after that edge. A second acknowledge on an edge with no expiry must clear the request.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DL_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DL_HI  = 3'd5;

  localparam int MODE_LSB = 17;

  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'd0,
    TM_PERIODIC = 2'd1,
    TM_DEADLINE = 2'd2,
    TM_RSVD     = 2'd3
  } tmode_e;
endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [3:0] div_cfg,
  output logic       tick
);
  logic [2:0]       code;
  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] pre_q;
  logic             bypass;

  assign code   = {div_cfg[3], div_cfg[1], div_cfg[0]};
  assign bypass = (code == 3'b111);
  assign lim    = ~({PRE_W{1'b1}} << (code + 3'd1));
  assign tick   = bypass | (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cit_countdown.sv
module cit_countdown
  import cit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  tmode_e           mode,
  output logic [CNT_W-1:0] cur,
  output logic             fire
);
  logic active;
  logic at_one;

  assign active = (mode != TM_DEADLINE);
  assign at_one = (cur == CNT_W'(1));
  assign fire   = tick & active & at_one & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick && active && cur != '0) begin
      if (at_one) cur <= (mode == TM_PERIODIC) ? reload_val : '0;
      else        cur <= cur - 1'b1;
    end
  end
endmodule

// File: rtl/cit_deadline.sv
module cit_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [TS_W-1:0] wr_val,
  input  logic [TS_W-1:0] ts,
  input  logic            enable,
  output logic [TS_W-1:0] dl,
  output logic            fire
);
  assign fire = enable & ~wr & (dl != '0) & (ts >= dl);

  always_ff @(posedge clk) begin
    if (rst)       dl <= '0;
    else if (wr)   dl <= wr_val;
    else if (fire) dl <= '0;
  end
endmodule

// File: rtl/cit_irq_hold.sv
module cit_irq_hold #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else if (fire && (!req || ack)) begin
      req <= 1'b1;
      vec <= vec_in;
    end else if (ack) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
  import cit_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8,
  parameter int PRE_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [REG_W-1:0]      rd_data,
  input  logic [TS_W-1:0]       ts_in,
  input  logic                  irq_ack,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vec
);
  localparam int HI_W = TS_W - REG_W;

  logic [VEC_W-1:0] vec_q;
  tmode_e           mode_q;
  logic [3:0]       div_q;
  logic [CNT_W-1:0] reload_q;
  logic [REG_W-1:0] dl_lo_stage;
  logic [CNT_W-1:0] cur;
  logic [TS_W-1:0]  dl;
  logic             tick;
  logic             cd_fire;
  logic             dl_fire;
  logic             any_fire;
  logic             wr_ctrl, wr_div, wr_reload, wr_lo, wr_hi;
  logic [REG_W-1:0] ctrl_view;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_div    = wr_en && (wr_addr == A_DIV);
  assign wr_reload = wr_en && (wr_addr == A_RELOAD);
  assign wr_lo     = wr_en && (wr_addr == A_DL_LO);
  assign wr_hi     = wr_en && (wr_addr == A_DL_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q       <= '0;
      mode_q      <= TM_ONESHOT;
      div_q       <= '0;
      reload_q    <= '0;
      dl_lo_stage <= '0;
    end else begin
      if (wr_ctrl) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mode_q <= tmode_e'(wr_data[MODE_LSB +: 2]);
      end
      if (wr_div)    div_q       <= wr_data[3:0];
      if (wr_reload) reload_q    <= wr_data[CNT_W-1:0];
      if (wr_lo)     dl_lo_stage <= wr_data;
    end
  end

  cit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_reload | wr_div),
    .div_cfg (div_q),
    .tick    (tick)
  );

  cit_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk        (clk),
    .rst        (rst),
    .load       (wr_reload),
    .load_val   (wr_data[CNT_W-1:0]),
    .reload_val (reload_q),
    .tick       (tick),
    .mode       (mode_q),
    .cur        (cur),
    .fire       (cd_fire)
  );

  cit_deadline #(.TS_W(TS_W)) u_dl (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_hi),
    .wr_val ({wr_data[HI_W-1:0], dl_lo_stage}),
    .ts     (ts_in),
    .enable (mode_q == TM_DEADLINE),
    .dl     (dl),
    .fire   (dl_fire)
  );

  assign any_fire = cd_fire | dl_fire;

  cit_irq_hold #(.VEC_W(VEC_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .fire   (any_fire),
    .vec_in (vec_q),
    .ack    (irq_ack),
    .req    (irq_req),
    .vec    (irq_vec)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[VEC_W-1:0]     = vec_q;
    ctrl_view[MODE_LSB +: 2] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:   rd_data <= ctrl_view;
        A_DIV:    rd_data <= REG_W'(div_q);
        A_RELOAD: rd_data <= REG_W'(reload_q);
        A_COUNT:  rd_data <= REG_W'(cur);
        A_DL_LO:  rd_data <= dl[REG_W-1:0];
        A_DL_HI:  rd_data <= REG_W'(dl[TS_W-1:REG_W]);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/core_irq_timer_chk.sv
module core_irq_timer_chk
  import cit_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  reload_q,
  input logic [TS_W-1:0]   dl,
  input logic              dl_fire
);
  logic wr_reload, wr_hi;
  assign wr_reload = wr_en && (wr_addr == A_RELOAD);
  assign wr_hi     = wr_en && (wr_addr == A_DL_HI);

  a_r3_load_count: assert property (@(posedge clk) disable iff (rst)
    wr_reload |=> (cur == $past(wr_data[CNT_W-1:0])));

  a_r6_reload_kept: assert property (@(posedge clk) disable iff (rst)
    !wr_reload |=> $stable(reload_q));

  a_r7_zero_sticks: assert property (@(posedge clk) disable iff (rst)
    (!wr_reload && cur == '0) |=> (cur == '0));

  a_r8_deadline_clears: assert property (@(posedge clk) disable iff (rst)
    (dl_fire && !wr_hi) |=> (dl == '0));

  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req);

  a_r11_vec_held: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> $stable(irq_vec));
endmodule

bind core_irq_timer core_irq_timer_chk #(
  .REG_W(REG_W), .CNT_W(CNT_W), .TS_W(TS_W), .VEC_W(VEC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .irq_ack  (irq_ack),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .cur      (cur),
  .reload_q (reload_q),
  .dl       (dl),
  .dl_fire  (dl_fire)
);

// File: tb/core_irq_timer_bench.sv
module core_irq_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] ts;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ts <= 64'd1000;
    else     ts <= ts + 64'd1;
  end

  core_irq_timer u_core_irq_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ts_in(ts), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  localparam logic [31:0] ONESHOT  = 32'h0 << 17;
  localparam logic [31:0] PERIODIC = 32'h1 << 17;
  localparam logic [31:0] DEADLINE = 32'h2 << 17;
  localparam logic [31:0] RSVD     = 32'h3 << 17;

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq_req) seen = 1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 req", irq_req, 0);
    chk("R1 vec", irq_vec, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, v); chk("R1 reload", v, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    rd(3'd5, v); chk("R1 deadline", v, 0);
  endtask

  task automatic t_oneshot();
    int n, s; logic [31:0] v;
    wr(3'd0, ONESHOT | 32'h31);
    wr(3'd1, 32'hB);
    wr(3'd2, 32'd10);
    wait_irq(n); chk("R2 R3 div1 delay", n, 10);
    chk("R10 vector", irq_vec, 8'h31);
    ack_pulse();
    quiet(30, s); chk("R4 single request", s, 0);
    rd(3'd3, v); chk("R4 count stays zero", v, 0);
  endtask

  task automatic t_divide();
    int n;
    wr(3'd1, 32'h1);
    wr(3'd2, 32'd5);
    wait_irq(n); chk("R2 div4 delay", n, 20);
    ack_pulse();
    wr(3'd1, 32'hB);
  endtask

  task automatic t_periodic();
    int n;
    wr(3'd0, PERIODIC | 32'h44);
    wr(3'd2, 32'd6);
    wait_irq(n); chk("R5 first period", n, 6);
    ack_pulse();
    wait_irq(n); chk("R5 second period", n + 1, 6);
    chk("R10 periodic vector", irq_vec, 8'h44);
    ack_pulse();
    wait_irq(n); chk("R5 third period", n + 1, 6);
    wr(3'd2, 32'd0);
    ack_pulse();
  endtask

  task automatic t_mode_keep();
    logic [31:0] v; int s;
    wr(3'd0, ONESHOT | 32'h12);
    wr(3'd2, 32'd1000);
    repeat (100) @(negedge clk);
    wr(3'd0, PERIODIC | 32'h12);
    rd(3'd2, v); chk("R6 reload kept", v, 1000);
    rd(3'd3, v);
    chk("R6 count continued", (v < 900 && v > 880) ? 1 : 0, 1);
    wr(3'd2, 32'd0);
    rd(3'd3, v); chk("R11 zero reload stops", v, 0);
    quiet(40, s); chk("R11 stopped no request", s, 0);
  endtask

  task automatic t_zero_to_periodic();
    int n, s; logic [31:0] v;
    wr(3'd0, ONESHOT | 32'h55);
    wr(3'd2, 32'd4);
    wait_irq(n);
    ack_pulse();
    wr(3'd0, PERIODIC | 32'h55);
    quiet(30, s); chk("R7 no reload from zero", s, 0);
    rd(3'd3, v); chk("R7 count zero", v, 0);
  endtask

  task automatic t_deadline_past();
    int n; logic [31:0] v;
    wr(3'd0, DEADLINE | 32'hA7);
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd0);
    wait_irq(n); chk("R8 immediate fire", n, 1);
    chk("R10 deadline vector", irq_vec, 8'hA7);
    rd(3'd4, v); chk("R8 low cleared", v, 0);
    rd(3'd5, v); chk("R8 high cleared", v, 0);
    ack_pulse();
  endtask

  task automatic t_deadline_future();
    int n, s; logic [63:0] tgt;
    tgt = ts + 64'd40;
    wr(3'd4, tgt[31:0]);
    wr(3'd5, tgt[63:32]);
    wait_irq(n); chk("R9 future deadline", n, 39);
    ack_pulse();
    tgt = ts + 64'd30;
    wr(3'd4, tgt[31:0]);
    wr(3'd5, tgt[63:32]);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd0);
    quiet(60, s); chk("R9 zero disarms", s, 0);
  endtask

  task automatic t_reserved();
    int n, s;
    wr(3'd0, RSVD | 32'h09);
    wr(3'd2, 32'd5);
    wait_irq(n); chk("R10 reserved mode delay", n, 5);
    ack_pulse();
    quiet(20, s); chk("R10 reserved acts one-shot", s, 0);
  endtask

  task automatic t_collide();
    int n, s;
    wr(3'd0, PERIODIC | 32'h77);
    wr(3'd2, 32'd3);
    wait_irq(n); chk("R11 first expiry", n, 3);
    @(negedge clk);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R11 ack with expiry keeps request", irq_req, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R11 ack clears request", irq_req, 0);
    wr(3'd2, 32'd0);
    quiet(10, s);
    if (irq_req) ack_pulse();
    quiet(10, s); chk("R11 held then stopped", s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_divide();
    t_periodic();
    t_mode_keep();
    t_zero_to_periodic();
    t_deadline_past();
    t_deadline_future();
    t_reserved();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule